// File: doc/BRIEF.md
# Crossbar Lookup Permutation Unit

This unit performs a table-lookup permutation on a data word. One operand, the table, is treated as a row of equal-width elements. The other operand, the index vector, is split into slots of the same width. Each result slot receives the table element named by the index in that same slot. An index that names no element of the table gives zero for that slot.

Two element widths are supported, 4-bit and 8-bit. An instruction word selects the width. The data width `XLEN` is a parameter and may be 32 or 64. Any instruction word that matches neither encoding raises an illegal flag and gives a zero result.

Operands enter on a valid/ready input stream, and results leave on a valid/ready output stream. With `OUT_REG=1` (the default), one output register sits between the lookup logic and the output port. An operand set is accepted on a rising edge where both `in_valid` and `in_ready` are high. Its result appears on the next cycle. While `out_valid` is high and `out_ready` is low, the output stays unchanged and `in_ready` is low. When the consumer takes the output, `in_ready` goes high in the same cycle. A new operand set can then be accepted on the same edge that drains the old result. With `OUT_REG=0`, the stream passes straight through: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `xbar_lookup_unit`

## Requirements
- R1: When `in_insn[31:25]=0010100`, `in_insn[14:12]=010` and `in_insn[6:0]=0110011`, nibble mode is selected. Result nibble k equals the table nibble at position i, where i is the value of nibble k of `in_index`.
- R2: When `in_insn[31:25]=0010100`, `in_insn[14:12]=100` and `in_insn[6:0]=0110011`, byte mode is selected. Result byte k equals the table byte at position i, where i is the value of byte k of `in_index`.
- R3: A slot whose index times the element width is XLEN or more gives zero. At XLEN=32 this covers nibble indexes 8 to 15 and byte indexes 4 to 255.
- R4: Each slot uses only its own index. An identity index vector returns the table unchanged, including its most significant slot.
- R5: An instruction word matching neither encoding sets `out_illegal` to 1 and gives a zero result. A matching word gives `out_illegal` = 0.
- R6: With `OUT_REG=1`, the result of an operand set accepted at one edge appears with `out_valid` high after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_illegal` stay unchanged, and `in_ready` is low. The operand set offered during that stall is accepted only once `out_ready` rises.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_insn | input | 32 | Instruction word selecting the mode |
| in_table | input | XLEN | Table of elements |
| in_index | input | XLEN | Per-slot index vector |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Permuted word |
| out_illegal | output | 1 | Instruction word not recognised |

## Verification
A wrong slot-select path shows up as a wrong element in the result of the very transaction that uses that index. Because each slot has its own selector, the error is tied to a single slot position. Identity vectors, shifted patterns and random patterns reach every slot and every index value. A wrong output-register state is visible one cycle after acceptance: `out_valid` is missing, a held result changes during a stall, or an offered operand set is taken while the output is full.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    XM_NONE = 2'd0,
    XM_NIB  = 2'd1,
    XM_BYTE = 2'd2
  } xbar_mode_e;

  localparam logic [6:0] XB_FUNCT7 = 7'b0010100;
  localparam logic [6:0] XB_OPCODE = 7'b0110011;
  localparam logic [2:0] XB_F3_NIB = 3'b010;
  localparam logic [2:0] XB_F3_BYTE = 3'b100;
  localparam int unsigned XB_NIB_W = 4;
  localparam int unsigned XB_BYTE_W = 8;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
  import xbar_pkg::*;
(
  input  logic [31:0] insn,
  output xbar_mode_e  mode,
  output logic        illegal
);
  logic fixed_ok;

  assign fixed_ok = (insn[31:25] == XB_FUNCT7) && (insn[6:0] == XB_OPCODE);

  always_comb begin
    mode = XM_NONE;
    if (fixed_ok) begin
      unique case (insn[14:12])
        XB_F3_NIB:  mode = XM_NIB;
        XB_F3_BYTE: mode = XM_BYTE;
        default:    mode = XM_NONE;
      endcase
    end
  end

  assign illegal = (mode == XM_NONE);
endmodule

// File: rtl/xbar_slot_sel.sv
module xbar_slot_sel #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned EW   = 4
) (
  input  logic [XLEN-1:0] tbl,
  input  logic [EW-1:0]   idx,
  output logic [EW-1:0]   elem
);
  localparam int unsigned NSLOT = XLEN / EW;

  always_comb begin
    elem = '0;
    for (int j = 0; j < NSLOT; j++) begin
      if (idx == EW'(j)) elem = tbl[j*EW +: EW];
    end
  end
endmodule

// File: rtl/xbar_perm_core.sv
module xbar_perm_core
  import xbar_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  xbar_mode_e      mode,
  input  logic [XLEN-1:0] tbl,
  input  logic [XLEN-1:0] index,
  output logic [XLEN-1:0] result
);
  localparam int unsigned NNIB  = XLEN / XB_NIB_W;
  localparam int unsigned NBYTE = XLEN / XB_BYTE_W;

  logic [XLEN-1:0] nib_res;
  logic [XLEN-1:0] byte_res;

  for (genvar k = 0; k < NNIB; k++) begin : g_nib
    xbar_slot_sel #(.XLEN(XLEN), .EW(XB_NIB_W)) u_sel (
      .tbl  (tbl),
      .idx  (index[k*XB_NIB_W +: XB_NIB_W]),
      .elem (nib_res[k*XB_NIB_W +: XB_NIB_W])
    );
  end

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    xbar_slot_sel #(.XLEN(XLEN), .EW(XB_BYTE_W)) u_sel (
      .tbl  (tbl),
      .idx  (index[k*XB_BYTE_W +: XB_BYTE_W]),
      .elem (byte_res[k*XB_BYTE_W +: XB_BYTE_W])
    );
  end

  always_comb begin
    unique case (mode)
      XM_NIB:  result = nib_res;
      XM_BYTE: result = byte_res;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/xbar_lookup_unit.sv
module xbar_lookup_unit
  import xbar_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_table,
  input  logic [XLEN-1:0] in_index,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  xbar_mode_e      mode;
  logic            dec_illegal;
  logic [XLEN-1:0] perm_res;

  xbar_decode u_dec (
    .insn    (in_insn),
    .mode    (mode),
    .illegal (dec_illegal)
  );

  xbar_perm_core #(.XLEN(XLEN)) u_core (
    .mode   (mode),
    .tbl    (in_table),
    .index  (in_index),
    .result (perm_res)
  );

  if (OUT_REG) begin : g_reg
    logic            vld_q;
    logic [XLEN-1:0] res_q;
    logic            ill_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        ill_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          res_q <= perm_res;
          ill_q <= dec_illegal;
        end
      end
    end

    assign out_valid   = vld_q;
    assign out_result  = res_q;
    assign out_illegal = ill_q;
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_result  = perm_res;
    assign out_illegal = dec_illegal;
  end
endmodule

// File: rtl/xbar_lookup_chk.sv
module xbar_lookup_chk
  import xbar_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     in_insn,
  input logic [XLEN-1:0] in_table,
  input logic [XLEN-1:0] in_index,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  localparam int unsigned NB = XLEN / 8;

  logic byte_sel;
  logic all_oor;
  logic bad_opc;

  assign byte_sel = (in_insn[31:25] == 7'b0010100) && (in_insn[14:12] == 3'b100)
                    && (in_insn[6:0] == 7'b0110011);
  assign bad_opc  = (in_insn[6:0] != 7'b0110011);

  always_comb begin
    all_oor = 1'b1;
    for (int k = 0; k < NB; k++) begin
      if (int'(in_index[k*8 +: 8]) < NB) all_oor = 1'b0;
    end
  end

  // R5: an illegal result is always zero
  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);

  if (OUT_REG) begin : g_seq
    // R5: wrong opcode is reported as illegal
    a_r5_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && bad_opc |=> out_illegal);
    // R3: byte mode with every index out of range yields zero
    a_r3_byte_oor: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && byte_sel && all_oor |=> out_result == '0);
    // R6: an accepted operand set produces a valid output next cycle
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    // R7: a stalled output holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal));
    // R7: no acceptance while the output is stalled
    a_r7_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
    // R8: output empty on leaving reset
    a_r8_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && in_ready);
  end
endmodule

bind xbar_lookup_unit xbar_lookup_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_insn     (in_insn),
  .in_table    (in_table),
  .in_index    (in_index),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/test_xbar_lookup_unit.sv
module test_xbar_lookup_unit;
  localparam int XLEN = 32;
  localparam logic [31:0] NIB_INSN  = {7'b0010100, 5'd3, 5'd2, 3'b010, 5'd1, 7'b0110011};
  localparam logic [31:0] BYTE_INSN = {7'b0010100, 5'd7, 5'd6, 3'b100, 5'd5, 7'b0110011};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_insn = '0;
  logic [XLEN-1:0] in_table = '0;
  logic [XLEN-1:0] in_index = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XLEN-1:0] out_result;
  logic            out_illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xbar_lookup_unit #(.XLEN(XLEN), .OUT_REG(1'b1)) i_xbar_lookup_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_insn, .in_table, .in_index,
    .out_valid, .out_ready, .out_result, .out_illegal
  );

  // Software model built from R1, R2, R3, R5
  function automatic logic [XLEN:0] model(logic [31:0] insn, logic [XLEN-1:0] a,
                                          logic [XLEN-1:0] b);
    int ew;
    logic [XLEN-1:0] r;
    r = '0;
    ew = 0;
    if (insn[31:25] == 7'b0010100 && insn[6:0] == 7'b0110011) begin
      if (insn[14:12] == 3'b010) ew = 4;
      else if (insn[14:12] == 3'b100) ew = 8;
    end
    if (ew == 0) return {1'b1, {XLEN{1'b0}}};
    for (int k = 0; k < XLEN / ew; k++) begin
      int idx;
      idx = int'((b >> (k * ew)) & ((1 << ew) - 1));
      if (idx * ew < XLEN)
        r |= ((a >> (idx * ew)) & XLEN'((1 << ew) - 1)) << (k * ew);
    end
    return {1'b0, r};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xact(string req, logic [31:0] insn, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN:0] m;
    m = model(insn, a, b);
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_table = a; in_index = b; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, 64'(out_result), 64'(m[XLEN-1:0]));
    check({req, " R5 illegal"}, 64'(out_illegal), 64'(m[XLEN]));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 out_valid", 64'(out_valid), 64'd0);
    check("R8 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_identity();
    xact("R4 R1 identity nib", NIB_INSN, 32'hFEDC_BA98, 32'h7654_3210);
    check("R4 nib top slot", 64'(out_result[31:28]), 64'hF);
    xact("R4 R2 identity byte", BYTE_INSN, 32'hA1B2_C3D4, 32'h0302_0100);
    check("R4 byte top slot", 64'(out_result), 64'hA1B2_C3D4);
    xact("R4 R1 reverse nib", NIB_INSN, 32'h1234_5678, 32'h0123_4567);
    check("R4 reverse value", 64'(out_result), 64'h8765_4321);
  endtask

  task automatic t_out_of_range();
    xact("R3 nib all oor", NIB_INSN, 32'hFFFF_FFFF, 32'h89AB_CDEF);
    check("R3 nib zero", 64'(out_result), 64'd0);
    xact("R3 byte all oor", BYTE_INSN, 32'hFFFF_FFFF, 32'hFF80_0504);
    check("R3 byte zero", 64'(out_result), 64'd0);
    xact("R3 nib edge 7/8", NIB_INSN, 32'h9000_0000, 32'h8787_8787);
    check("R3 nib edge value", 64'(out_result), 64'h0909_0909);
    xact("R3 byte edge 3/4", BYTE_INSN, 32'h5A00_0000, 32'h0304_03FF);
    check("R3 byte edge value", 64'(out_result), 64'h5A00_5A00);
  endtask

  task automatic t_illegal();
    xact("R5 bad opcode", {NIB_INSN[31:7], 7'b0010011}, 32'h1234_5678, 32'h0);
    xact("R5 bad funct3", {NIB_INSN[31:15], 3'b001, NIB_INSN[11:0]}, 32'h1234_5678, 32'h0);
    xact("R5 bad funct7", {7'b0010101, NIB_INSN[24:0]}, 32'hFFFF_FFFF, 32'h0);
    check("R5 zero result", 64'(out_result), 64'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 2 == 0) xact("R1 random nib", NIB_INSN, a, b);
      else            xact("R2 random byte", BYTE_INSN, a, b & 32'h0707_0707);
    end
    for (int i = 0; i < 40; i++) begin
      logic [31:0] w;
      w = {7'b0010100, 10'($urandom()), 3'($urandom()), 5'd1, 7'b0110011};
      xact("R5 random funct3", w, $urandom(), $urandom());
    end
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    in_valid = 1'b1; in_insn = NIB_INSN; in_table = 32'hCAFE_BABE; in_index = 32'h0000_0000;
    out_ready = 1'b0;
    @(negedge clk);
    check("R6 stall valid", 64'(out_valid), 64'd1);
    check("R7 stall ready low", 64'(in_ready), 64'd0);
    in_insn = BYTE_INSN; in_table = 32'h1122_3344; in_index = 32'h0001_0203;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 held result", 64'(out_result), 64'hEEEE_EEEE);
      check("R7 held valid", 64'(out_valid), 64'd1);
      check("R7 ready low", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second accepted", 64'(out_result), 64'h4433_2211);
    check("R7 second valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R7 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_out_of_range();
    t_illegal();
    t_backpressure();
    t_random();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule